// File: doc/BRIEF.md
# Nonvolatile Page Commit Controller

This block sits behind a two-wire serial slave and in front of a nonvolatile configuration array. Data bytes aimed at the nonvolatile store are not written on arrival. They collect in a 16-entry page buffer, indexed by the low four bits of the byte address. When the slave reports the STOP that closes the frame, the controller runs a program cycle. The cycle copies every buffered entry into the array and keeps a busy flag raised for a programmable number of clock cycles. The slave uses that flag to refuse any new command.

Bytes aimed at the volatile working image are written at once. A write-protect input stops the program cycle from starting, but bytes are still accepted while it is set. After every reset the controller walks the whole address space and loads the working image from the nonvolatile array, so the saved configuration takes effect. A combinational read port shows either image.

Top module: `nv_commit_ctrl`

## Requirements
- R1: A byte with `wr_nv`=0 accepted while `busy` is low is visible in the working image (`rd_nv`=0) one cycle later, and it raises no busy period.
- R2: A byte with `wr_nv`=1 leaves the nonvolatile array (`rd_nv`=1) unchanged until the frame is closed by `frm_stop`.
- R3: A `frm_stop` accepted while at least one page entry is buffered and `wp` is low raises `busy` from the next cycle for exactly `PROG_CYCLES` cycles. After that, the array holds every buffered byte at address {upper four bits of the frame's last byte address, entry index}.
- R4: The entry index is bits [3:0] of the byte address. A later byte with the same index replaces the earlier one, so the last value written wins.
- R5: Only entries written since the most recent accepted `frm_start` are committed. A repeated START discards the bytes before it, and array bytes of entries not written are left unchanged.
- R6: With `wp`=1 at STOP, no program cycle starts: `busy` stays low and the array is unchanged. The buffer is emptied, so a later STOP with no new bytes commits nothing.
- R7: A STOP that closes a frame with no data bytes starts no program cycle.
- R8: While `busy` is high, every input (`frm_start`, `frm_stop`, `wr_valid`) is ignored, whether the byte is volatile or nonvolatile.
- R9: `busy` is high during reset and for 2^`AW` cycles after it is released. Once it falls, every working-image address holds the nonvolatile array's value, which replaces any earlier volatile write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the boot copy |
| frm_start | input | 1 | One-cycle pulse: START or repeated START seen |
| frm_stop | input | 1 | One-cycle pulse: STOP seen |
| wr_valid | input | 1 | One-cycle pulse: a data byte was received |
| wr_nv | input | 1 | Target of the byte: 1 nonvolatile, 0 volatile |
| wr_addr | input | AW | Byte address |
| wr_data | input | DW | Byte value |
| wp | input | 1 | Write protect; blocks only the program cycle |
| rd_nv | input | 1 | Read select: 1 nonvolatile array, 0 working image |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| busy | output | 1 | Program cycle or boot copy in progress |

## Verification
The bench goes after the page wrap, where a design that keeps the first byte instead of the last would commit stale data. It tests a repeated START, where a mask that is not cleared would commit bytes from an aborted frame. It also checks that unwritten entries leave their array bytes alone, which a full-page copy would break. Write-protect, empty-frame and stray STOP cases look for a spurious busy period. Traffic sent during busy must not reach either image. After a second reset the working image is compared with the array at all addresses, so a boot walk that is short by one address, or that lets a volatile write survive, is caught.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;

    // Sequencer view of one program step.
    typedef struct packed {
        logic launch;
        logic done;
    } prog_evt_t;

    // Larger of two counts, used for counter sizing.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvc_page_buf.sv
module nvc_page_buf #(
    parameter int DW      = 8,
    parameter int PAGE_AW = 4,
    parameter int HI_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [HI_W-1:0]    wr_hi,
    input  logic [DW-1:0]      wr_data,
    input  logic               clr,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic               rd_vld,
    output logic               any_vld,
    output logic [HI_W-1:0]    page_hi
);
    localparam int PAGE = 1 << PAGE_AW;

    logic [DW-1:0]   entry [PAGE];
    logic [PAGE-1:0] mask;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            entry[wr_idx] <= wr_data;
            page_hi       <= wr_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else begin
            if (clr)   mask         <= '0;
            if (wr_en) mask[wr_idx] <= 1'b1;
        end
    end

    assign rd_data = entry[rd_idx];
    assign rd_vld  = mask[rd_idx];
    assign any_vld = |mask;

endmodule

// File: rtl/nvc_seq.sv
module nvc_seq
    import nvc_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PAGE_AW     = 4,
    parameter int PROG_CYCLES = 4000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_acc,
    input  logic               any_vld,
    input  logic               wp,
    input  logic               ent_vld,
    output logic               busy,
    output prog_evt_t          evt,
    output logic [PAGE_AW-1:0] pidx,
    output logic               nv_we,
    output logic               boot_we,
    output logic [AW-1:0]      bidx
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             pdone;

    assign evt.launch = (state == ST_IDLE) && stop_acc && any_vld && !wp;
    assign evt.done   = (state == ST_PROG) && (cnt == '0);
    assign busy       = (state != ST_IDLE);
    assign nv_we      = (state == ST_PROG) && !pdone && ent_vld;
    assign boot_we    = (state == ST_BOOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BOOT;
            bidx  <= '0;
            cnt   <= '0;
            pidx  <= '0;
            pdone <= 1'b1;
        end else begin
            case (state)
                ST_BOOT: begin
                    bidx <= bidx + 1'b1;
                    if (bidx == {AW{1'b1}}) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (evt.launch) begin
                        state <= ST_PROG;
                        cnt   <= CNT_W'(PROG_CYCLES - 1);
                        pidx  <= '0;
                        pdone <= 1'b0;
                    end
                end
                ST_PROG: begin
                    if (!pdone) begin
                        pidx <= pidx + 1'b1;
                        if (pidx == {PAGE_AW{1'b1}}) pdone <= 1'b1;
                    end
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nvc_store.sv
module nvc_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          nv_we,
    input  logic [AW-1:0] nv_waddr,
    input  logic [DW-1:0] nv_wdata,
    input  logic          boot_we,
    input  logic [AW-1:0] boot_addr,
    input  logic          vol_we,
    input  logic [AW-1:0] vol_addr,
    input  logic [DW-1:0] vol_data,
    input  logic          rd_nv,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] nv_mem [DEPTH];
    logic [DW-1:0] wk_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (nv_we) nv_mem[nv_waddr] <= nv_wdata;
    end

    always_ff @(posedge clk) begin
        if (boot_we)     wk_mem[boot_addr] <= nv_mem[boot_addr];
        else if (vol_we) wk_mem[vol_addr]  <= vol_data;
    end

    assign rd_data = rd_nv ? nv_mem[rd_addr] : wk_mem[rd_addr];

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
    import nvc_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int PAGE_AW     = 4,
    parameter int PROG_CYCLES = 4000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_start,
    input  logic          frm_stop,
    input  logic          wr_valid,
    input  logic          wr_nv,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wp,
    input  logic          rd_nv,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam int HI_W = AW - PAGE_AW;

    logic               accept, start_acc, stop_acc, nvb_we, vol_we;
    logic               any_vld, ent_vld, nv_we, boot_we, buf_clr;
    logic [DW-1:0]      ent_data;
    logic [HI_W-1:0]    page_hi;
    logic [PAGE_AW-1:0] pidx;
    logic [AW-1:0]      bidx;
    prog_evt_t          evt;

    assign accept    = !busy;
    assign start_acc = frm_start && accept;
    assign stop_acc  = frm_stop  && accept;
    assign nvb_we    = wr_valid && wr_nv  && accept;
    assign vol_we    = wr_valid && !wr_nv && accept;
    assign buf_clr   = start_acc || (stop_acc && !evt.launch) || evt.done;

    nvc_page_buf #(.DW(DW), .PAGE_AW(PAGE_AW), .HI_W(HI_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (nvb_we),
        .wr_idx  (wr_addr[PAGE_AW-1:0]),
        .wr_hi   (wr_addr[AW-1:PAGE_AW]),
        .wr_data (wr_data),
        .clr     (buf_clr),
        .rd_idx  (pidx),
        .rd_data (ent_data),
        .rd_vld  (ent_vld),
        .any_vld (any_vld),
        .page_hi (page_hi)
    );

    nvc_seq #(.AW(AW), .PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stop_acc (stop_acc),
        .any_vld  (any_vld),
        .wp       (wp),
        .ent_vld  (ent_vld),
        .busy     (busy),
        .evt      (evt),
        .pidx     (pidx),
        .nv_we    (nv_we),
        .boot_we  (boot_we),
        .bidx     (bidx)
    );

    nvc_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .nv_we     (nv_we),
        .nv_waddr  ({page_hi, pidx}),
        .nv_wdata  (ent_data),
        .boot_we   (boot_we),
        .boot_addr (bidx),
        .vol_we    (vol_we),
        .vol_addr  (wr_addr),
        .vol_data  (wr_data),
        .rd_nv     (rd_nv),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/nvc_checker.sv
module nvc_checker
    import nvc_pkg::*;
#(
    parameter int PROG_CYCLES = 4000000
) (
    input logic clk,
    input logic rst,
    input logic frm_stop,
    input logic wp,
    input logic busy,
    input logic any_vld,
    input logic launch
);
    localparam int RUN_W = $clog2(max_int(PROG_CYCLES, 2) + 2);

    logic [RUN_W-1:0] run;
    logic             in_prog;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= '0;
            in_prog <= 1'b0;
        end else if (launch) begin
            run     <= '0;
            in_prog <= 1'b1;
        end else if (in_prog && busy) begin
            run <= run + 1'b1;
        end else begin
            run     <= '0;
            in_prog <= 1'b0;
        end
    end

    assert_boot_busy_R9: assert property (@(posedge clk) rst |=> busy);

    assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (frm_stop && !busy && any_vld && !wp) |=> busy);

    assert_prog_len_R3: assert property (@(posedge clk) disable iff (rst)
        run <= RUN_W'(PROG_CYCLES));

    assert_wp_block_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_stop && !busy && wp) |=> !busy);

    assert_empty_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (frm_stop && !busy && !any_vld) |=> !busy);

endmodule

bind nv_commit_ctrl nvc_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frm_stop (frm_stop),
    .wp       (wp),
    .busy     (busy),
    .any_vld  (any_vld),
    .launch   (evt.launch)
);

// File: tb/tb_nv_commit_ctrl.sv
`timescale 1ns/1ps
module tb_nv_commit_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int P  = 40;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frm_start = 0, frm_stop = 0, wr_valid = 0, wr_nv = 0, wp = 0, rd_nv = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nv_commit_ctrl #(.AW(AW), .DW(DW), .PAGE_AW(4), .PROG_CYCLES(P)) dut (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
        .wr_valid(wr_valid), .wr_nv(wr_nv), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp(wp), .rd_nv(rd_nv), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // {address, data} pairs for volatile writes
    localparam logic [15:0] VOL_VEC [8] = '{
        16'h005A, 16'h07C3, 16'h3011, 16'h3F22,
        16'h80F0, 16'hFF0F, 16'h4199, 16'h1001
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic nv, input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_nv = nv; rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic start_pulse();
        frm_start = 1; @(negedge clk); frm_start = 0;
    endtask

    task automatic stop_pulse();
        frm_stop = 1; @(negedge clk); frm_stop = 0;
    endtask

    task automatic send(input logic nv, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = 1; wr_nv = nv; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic do_reset(input string req);
        int n;
        rst = 1;
        repeat (3) @(negedge clk);
        chk({req, " busy in reset"}, int'(busy), 1);
        rst = 0;
        busy_len(n);
        chk({req, " boot length"}, n, DEPTH);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d, e;
        int n;
        @(negedge clk);
        do_reset("R9");

        // R1: volatile writes, table driven
        for (int i = 0; i < 8; i++) begin
            send(1'b0, VOL_VEC[i][15:8], VOL_VEC[i][7:0]);
            chk("R1 no busy", int'(busy), 0);
            rd(1'b0, VOL_VEC[i][15:8], d);
            chk("R1 working image", int'(d), int'(VOL_VEC[i][7:0]));
        end

        // R3: first page commit
        start_pulse();
        send(1'b1, 8'h30, 8'hA0); send(1'b1, 8'h31, 8'hA1);
        send(1'b1, 8'h32, 8'hA2); send(1'b1, 8'h33, 8'hA3);
        stop_pulse();
        busy_len(n);
        chk("R3 busy length", n, P);
        rd(1'b1, 8'h30, d); chk("R3 byte 0x30", int'(d), 'hA0);
        rd(1'b1, 8'h33, d); chk("R3 byte 0x33", int'(d), 'hA3);

        // R2 and R4: deferred write and wrap replacement
        start_pulse();
        send(1'b1, 8'h31, 8'h55);
        rd(1'b1, 8'h31, d); chk("R2 held until STOP", int'(d), 'hA1);
        send(1'b1, 8'h3E, 8'h10);
        send(1'b1, 8'h31, 8'h66);
        rd(1'b1, 8'h31, d); chk("R2 held until STOP", int'(d), 'hA1);
        stop_pulse();
        busy_len(n);
        chk("R3 busy length", n, P);
        rd(1'b1, 8'h31, d); chk("R4 last value wins", int'(d), 'h66);
        rd(1'b1, 8'h3E, d); chk("R4 index from low bits", int'(d), 'h10);
        rd(1'b1, 8'h32, d); chk("R5 unwritten entry kept", int'(d), 'hA2);

        // R5: repeated START discards earlier bytes
        start_pulse();
        send(1'b1, 8'h33, 8'h99);
        start_pulse();
        send(1'b1, 8'h34, 8'h44);
        stop_pulse();
        busy_len(n);
        rd(1'b1, 8'h33, d); chk("R5 aborted byte dropped", int'(d), 'hA3);
        rd(1'b1, 8'h34, d); chk("R5 new byte committed", int'(d), 'h44);

        // R6: write protect
        wp = 1;
        start_pulse();
        send(1'b1, 8'h30, 8'hEE);
        stop_pulse();
        chk("R6 no busy under wp", int'(busy), 0);
        wp = 0;
        repeat (2) @(negedge clk);
        rd(1'b1, 8'h30, d); chk("R6 array unchanged", int'(d), 'hA0);
        stop_pulse();
        chk("R6 buffer emptied", int'(busy), 0);

        // R7: frame with no data bytes
        start_pulse();
        stop_pulse();
        chk("R7 empty frame", int'(busy), 0);

        // R8: everything ignored while busy
        start_pulse();
        send(1'b1, 8'h40, 8'h12);
        stop_pulse();
        chk("R8 busy raised", int'(busy), 1);
        send(1'b0, 8'h07, 8'hCD);
        start_pulse();
        send(1'b1, 8'h30, 8'h34);
        stop_pulse();
        busy_len(n);
        rd(1'b0, 8'h07, d); chk("R8 volatile write dropped", int'(d), 'hC3);
        rd(1'b1, 8'h40, d); chk("R8 commit done", int'(d), 'h12);
        rd(1'b1, 8'h30, d); chk("R8 nv byte dropped", int'(d), 'hA0);
        stop_pulse();
        chk("R8 no stray commit", int'(busy), 0);

        // R9: boot copy after a second reset
        do_reset("R9");
        rd(1'b0, 8'h30, d); chk("R9 volatile replaced", int'(d), 'hA0);
        rd(1'b0, 8'h31, d); chk("R9 boot copy 0x31", int'(d), 'h66);
        rd(1'b0, 8'h40, d); chk("R9 boot copy 0x40", int'(d), 'h12);
        n = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd(1'b0, AW'(a), d);
            rd(1'b1, AW'(a), e);
            if (d !== e) n++;
        end
        chk("R9 images equal", n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule